// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the programming registers for a set of channels belonging to a descriptor-driven DMA engine. A host reaches them over a plain 32-bit word bus that has a write strobe, an address and write data, and a read-data path that follows the address combinationally. Each channel owns a 128-byte slot, and sixteen word registers sit at the bottom of that slot. The registers cover control, status, a two-word command pointer, three select words that later stages use for interrupt, branch and wait decisions, a transfer-mode word and a few general words.

Software never writes the status word directly. It writes the control word, which carries a 16-bit mask in its upper half and a 16-bit value in its lower half. Only the run, pause, flush and wake flags and the 8-bit device-status field take part in that merge. Starting a channel raises a one-cycle start pulse toward the command sequencer. Stopping it drops the active and dead flags. While the channel is busy, the low command-pointer word is locked. An accepted write to that word is aligned to 16 bytes and raises a one-cycle request to fetch the descriptor it points at.

Top module: `dma_chan_regs`

## Requirements
- R1: Channel number is bus_addr[11:7] and word index is bus_addr[5:2]. Words 0x0 (control), 0x2, 0x3, 0x4, 0x5, 0x6, 0x7, 0x8, 0x9, 0xB and 0xC read back the last value written to them. Control reads back the whole word as written.
- R2: Word indexes 0xA, 0xD, 0xE and 0xF read as zero. The upper half of each slot (bus_addr[6]=1) also reads as zero, and so does any address with bus_addr[1:0] not equal to 0. Writes to any of these change no register.
- R3: A control write takes mask m = wdata[31:16] & 0xF0FF and value v = wdata[15:0]. Status[15:0] then becomes (v & m) | (old & ~m). The flag positions are RUN=15, PAUSE=14, FLUSH=13, WAKE=12, DEAD=11, ACTIVE=10 and BT=8, and device status is bits 7:0. Status[31:16] reads as zero.
- R4: A bus write to word 0x1 (status) leaves status unchanged.
- R5: If a control write moves RUN from 0 to 1 while ACTIVE is 0, it also sets ACTIVE. In the cycle after that write, start_pulse is 1 for one cycle and start_ch holds the channel number. A control write while RUN is already 1 gives no pulse.
- R6: If a control write moves RUN from 1 to 0, it also clears ACTIVE and DEAD.
- R7: A write to word 0x3 is ignored while RUN or ACTIVE is set: the stored value is kept and fetch_req stays 0.
- R8: An accepted write to word 0x3 stores wdata with bits 3:0 forced to zero. In the cycle after the write, fetch_req is 1 for one cycle, fetch_ch holds the channel number and fetch_ptr holds the aligned value. A write to word 0x2 is never locked.
- R9: Reset, synchronous and active low, clears every register of every channel to zero and drops both pulses.
- R10: A write to one channel changes no register of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| fetch_ch | output | 5 | Channel that requested the fetch |
| fetch_ptr | output | 32 | Aligned command pointer to fetch from |
| start_pulse | output | 1 | One-cycle kick to the command sequencer |
| start_ch | output | 5 | Channel that was started |

## Verification
The bench targets the masked merge with mask bits placed on the protected ACTIVE, DEAD and BT positions. A design that honoured those mask bits would clear ACTIVE or change BT. It writes the low command pointer while the channel runs and expects the old value and no fetch request. A missing lock would show as a new value or a stray pulse. It sets RUN twice and counts start pulses, which catches a level-triggered kick. It also checks that stopping clears ACTIVE, that the pointer comes back aligned, and that reserved, misaligned and out-of-file addresses leave other channels and registers untouched. A decoder that aliased those addresses would corrupt storage that is visible on read-back.

// File: rtl/dcr_pkg.sv
// Shared constants for the DMA channel register file: word indexes,
// status flag positions and the set of bits a control write may touch.
package dcr_pkg;
    localparam int unsigned IDX_W      = 4;
    localparam int unsigned NREG       = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IDX_CTRL  = 4'h0;
    localparam logic [IDX_W-1:0] IDX_STAT  = 4'h1;
    localparam logic [IDX_W-1:0] IDX_CPHI  = 4'h2;
    localparam logic [IDX_W-1:0] IDX_CPLO  = 4'h3;

    localparam int unsigned B_RUN    = 15;
    localparam int unsigned B_PAUSE  = 14;
    localparam int unsigned B_FLUSH  = 13;
    localparam int unsigned B_WAKE   = 12;
    localparam int unsigned B_DEAD   = 11;
    localparam int unsigned B_ACTIVE = 10;
    localparam int unsigned B_BT     = 8;

    // Bits a control write may alter: the four flags and device status.
    localparam logic [15:0] CTRL_WMASK = 16'hF0FF;

    // True for words backed by plain storage (not control/status/reserved).
    function automatic logic is_plain(input logic [IDX_W-1:0] idx);
        case (idx)
            4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
            4'h8, 4'h9, 4'hB, 4'hC: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dcr_addr_dec.sv
// Address decoder: splits a byte address into channel number and word
// index, and flags whether it hits the sixteen-word register file.
// Assumes CH_SHIFT > IDX_W + 2 so that each slot has an unused upper part.
module dcr_addr_dec
    import dcr_pkg::*;
#(
    parameter int unsigned CH_SHIFT = 7,
    parameter int unsigned CH_W     = 5,
    localparam int unsigned ADDR_W  = CH_SHIFT + CH_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    // Field extraction and hit test.
    always_comb begin
        ch  = addr[CH_SHIFT +: CH_W];
        idx = addr[2 +: IDX_W];
        hit = (addr[CH_SHIFT-1:IDX_W+2] == '0) && (addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/dcr_chan.sv
// One channel's registers: control word, status flags and plain words.
// Control writes merge into status under mask; the low command pointer
// is locked while RUN or ACTIVE is set. Reports accepted pointer writes
// and run starts as combinational fire signals for the top to register.
module dcr_chan
    import dcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             fetch_fire,
    output logic             start_fire
);
    logic [31:0] ctrl_q;
    logic [15:0] stat_q;
    logic [31:0] word_q [NREG];

    logic [15:0] eff_mask;
    logic [15:0] merged;
    logic [15:0] stat_nx;
    logic        run_rise;
    logic        run_fall;
    logic        busy;
    logic        ctrl_hit;
    logic        cplo_hit;

    // Next status value for a control write.
    always_comb begin
        eff_mask = wdata[31:16] & CTRL_WMASK;
        merged   = (wdata[15:0] & eff_mask) | (stat_q & ~eff_mask);
        run_rise = !stat_q[B_RUN] && merged[B_RUN] && !stat_q[B_ACTIVE];
        run_fall = stat_q[B_RUN] && !merged[B_RUN];
        stat_nx  = merged;
        if (run_fall) begin
            stat_nx[B_ACTIVE] = 1'b0;
            stat_nx[B_DEAD]   = 1'b0;
        end
        if (run_rise) begin
            stat_nx[B_ACTIVE] = 1'b1;
        end
    end

    // Write qualification and fire signals.
    always_comb begin
        busy       = stat_q[B_RUN] || stat_q[B_ACTIVE];
        ctrl_hit   = wr_en && (idx == IDX_CTRL);
        cplo_hit   = wr_en && (idx == IDX_CPLO);
        fetch_fire = cplo_hit && !busy;
        start_fire = ctrl_hit && run_rise;
    end

    // Control and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else if (ctrl_hit) begin
            ctrl_q <= wdata;
            stat_q <= stat_nx;
        end
    end

    // Plain storage words, with pointer lock and alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) word_q[i] <= '0;
        end else if (wr_en && is_plain(idx)) begin
            if (idx == IDX_CPLO) begin
                if (!busy) word_q[idx] <= {wdata[31:4], 4'h0};
            end else begin
                word_q[idx] <= wdata;
            end
        end
    end

    // Read selection for the addressed word.
    always_comb begin
        if (idx == IDX_CTRL)      rdata = ctrl_q;
        else if (idx == IDX_STAT) rdata = {16'h0000, stat_q};
        else if (is_plain(idx))   rdata = word_q[idx];
        else                      rdata = '0;
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Top of the DMA channel register file. Decodes the word bus, steers
// writes to one of NUM_CH channel slices, muxes read data back, and
// registers the fetch request and start pulse with their channel number.
// Assumes NUM_CH is a power of two and one bus access per cycle.
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int unsigned NUM_CH   = 32,
    parameter int unsigned CH_SHIFT = 7,
    localparam int unsigned CH_W    = $clog2(NUM_CH),
    localparam int unsigned ADDR_W  = CH_SHIFT + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fetch_req,
    output logic [CH_W-1:0]   fetch_ch,
    output logic [31:0]       fetch_ptr,
    output logic              start_pulse,
    output logic [CH_W-1:0]   start_ch
);
    logic [CH_W-1:0]  dec_ch;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_hit;
    logic [31:0]      ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] fetch_fire_v;
    logic [NUM_CH-1:0] start_fire_v;

    dcr_addr_dec #(.CH_SHIFT(CH_SHIFT), .CH_W(CH_W)) u_dec (
        .addr (bus_addr),
        .ch   (dec_ch),
        .idx  (dec_idx),
        .hit  (dec_hit)
    );

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        logic wr_sel;
        // Write select for this channel slice.
        always_comb wr_sel = bus_we && dec_hit && (dec_ch == CH_W'(c));
        dcr_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_sel),
            .idx        (dec_idx),
            .wdata      (bus_wdata),
            .rdata      (ch_rdata[c]),
            .fetch_fire (fetch_fire_v[c]),
            .start_fire (start_fire_v[c])
        );
    end

    // Read-data mux across channels.
    always_comb bus_rdata = dec_hit ? ch_rdata[dec_ch] : '0;

    // Registered fetch request with its channel and aligned pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req <= 1'b0;
            fetch_ch  <= '0;
            fetch_ptr <= '0;
        end else begin
            fetch_req <= |fetch_fire_v;
            if (|fetch_fire_v) begin
                fetch_ch  <= dec_ch;
                fetch_ptr <= {bus_wdata[31:4], 4'h0};
            end
        end
    end

    // Registered sequencer start pulse with its channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            start_ch    <= '0;
        end else begin
            start_pulse <= |start_fire_v;
            if (|start_fire_v) start_ch <= dec_ch;
        end
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
// Checker for dma_chan_regs, observing only its ports; bound below.
module dma_chan_regs_chk #(
    parameter int unsigned CH_SHIFT = 7,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned CH_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              fetch_req,
    input logic [CH_W-1:0]   fetch_ch,
    input logic [31:0]       fetch_ptr,
    input logic              start_pulse,
    input logic [CH_W-1:0]   start_ch
);
    logic       in_file;
    logic [3:0] widx;
    // Independent view of the word index and file hit.
    always_comb begin
        widx    = bus_addr[5:2];
        in_file = (bus_addr[CH_SHIFT-1:6] == '0) && (bus_addr[1:0] == 2'b00);
    end

    // R8: a fetch request follows a write to the low pointer word.
    a_r8_fetch_source: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> ($past(bus_we) && $past(widx) == 4'h3 && $past(in_file)));

    // R8: the pointer handed out is 16-byte aligned.
    a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_ptr[3:0] == 4'h0));

    // R5: a start pulse follows a control write that sets RUN.
    a_r5_start_source: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(bus_we) && $past(widx) == 4'h0 &&
                         $past(bus_wdata[31]) && $past(bus_wdata[15])));

    // R5: one bus write can produce only one of the two pulses.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fetch_req, start_pulse}) <= 1);

    // R5: a running channel always reads as active.
    a_r5_run_active: assert property (@(posedge clk) disable iff (!rst_n)
        (in_file && widx == 4'h1 && bus_rdata[15]) |-> bus_rdata[10]);

    // R3: the upper half of status reads zero.
    a_r3_stat_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_file && widx == 4'h1) |-> (bus_rdata[31:16] == 16'h0000));

    // R2: reserved words read zero.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_file && (widx == 4'hA || widx == 4'hD || widx == 4'hE || widx == 4'hF))
        |-> (bus_rdata == 32'h0));

    // R9: leaving reset, whatever is addressed reads zero.
    a_r9_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (bus_rdata == 32'h0 && !fetch_req && !start_pulse));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
    .CH_SHIFT (CH_SHIFT),
    .ADDR_W   (ADDR_W),
    .CH_W     (CH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .fetch_req   (fetch_req),
    .fetch_ch    (fetch_ch),
    .fetch_ptr   (fetch_ptr),
    .start_pulse (start_pulse),
    .start_ch    (start_ch)
);

// File: tb/dma_chan_regs_test.sv
// Scoreboard bench: read tasks queue expected words, a monitor process
// pops and compares them at the falling edge; pulse checks are direct.
module dma_chan_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fetch_req;
    logic [4:0]  fetch_ch;
    logic [31:0] fetch_ptr;
    logic        start_pulse;
    logic [4:0]  start_ch;

    int          n_checks = 0;
    int          n_fail = 0;
    logic        rd_pend = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        done = 1'b0;

    dma_chan_regs uut (
        .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .fetch_req (fetch_req), .fetch_ch (fetch_ch), .fetch_ptr (fetch_ptr),
        .start_pulse (start_pulse), .start_ch (start_ch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] ad(input int ch, input int idx);
        return 12'(ch * 128 + idx * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        rd_pend = 1'b1;
        @(negedge clk); #1;
        rd_pend = 1'b0;
    endtask

    // Monitor: compare read data against the oldest queued expectation.
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R9 fetch_req in reset", {31'b0, fetch_req}, 32'h0);
        rst_n = 1'b1;
        bus_rd(ad(0, 0), 32'h0, "R9 ch0 control");
        bus_rd(ad(31, 3), 32'h0, "R9 ch31 pointer low");
        bus_rd(ad(5, 1), 32'h0, "R9 ch5 status");

        // R1 plain words
        bus_wr(ad(2, 4), 32'h000F_0003);
        bus_rd(ad(2, 4), 32'h000F_0003, "R1 ch2 interrupt select");
        bus_wr(ad(7, 5), 32'h1111_2222);
        bus_wr(ad(7, 6), 32'h3333_4444);
        bus_wr(ad(7, 7), 32'h5555_6666);
        bus_wr(ad(7, 11), 32'hDEAD_BEEF);
        bus_wr(ad(7, 12), 32'hCAFE_F00D);
        bus_rd(ad(7, 5), 32'h1111_2222, "R1 branch select");
        bus_rd(ad(7, 6), 32'h3333_4444, "R1 wait select");
        bus_rd(ad(7, 7), 32'h5555_6666, "R1 transfer mode");
        bus_rd(ad(7, 11), 32'hDEAD_BEEF, "R1 word 0xB");
        bus_rd(ad(7, 12), 32'hCAFE_F00D, "R1 word 0xC");
        bus_rd(ad(3, 4), 32'h0, "R10 ch3 untouched by ch2");

        // R2 reserved, upper slot and misaligned
        bus_wr(ad(2, 10), 32'hFFFF_FFFF);
        bus_rd(ad(2, 10), 32'h0, "R2 reserved 0xA");
        bus_wr(ad(2, 20), 32'hFFFF_FFFF);
        bus_rd(ad(2, 20), 32'h0, "R2 upper slot word");
        bus_rd(ad(2, 4), 32'h000F_0003, "R2 upper slot aliasing");
        bus_wr(ad(2, 4) + 12'd1, 32'h0000_1234);
        bus_rd(ad(2, 4), 32'h000F_0003, "R2 misaligned write ignored");

        // R4 status direct write
        bus_wr(ad(2, 1), 32'hFFFF_FFFF);
        bus_rd(ad(2, 1), 32'h0, "R4 status write ignored");

        // R3 masked merges
        bus_wr(ad(2, 0), 32'h00FF_00A5);
        bus_rd(ad(2, 1), 32'h0000_00A5, "R3 device status set");
        bus_wr(ad(2, 0), 32'h000F_0000);
        bus_rd(ad(2, 1), 32'h0000_00A0, "R3 partial mask clear");
        bus_wr(ad(2, 0), 32'h0F00_0F00);
        bus_rd(ad(2, 1), 32'h0000_00A0, "R3 protected bits unchanged");
        bus_wr(ad(2, 0), 32'h7000_7000);
        bus_rd(ad(2, 1), 32'h0000_70A0, "R3 pause flush wake");
        bus_rd(ad(2, 0), 32'h7000_7000, "R1 control readback");

        // R8 accepted pointer write
        bus_wr(ad(4, 3), 32'h1234_567F);
        chk("R8 fetch_req high", {31'b0, fetch_req}, 32'h1);
        chk("R8 fetch_ch", {27'b0, fetch_ch}, 32'd4);
        chk("R8 fetch_ptr aligned", fetch_ptr, 32'h1234_5670);
        @(posedge clk); #1;
        chk("R8 fetch_req one cycle", {31'b0, fetch_req}, 32'h0);
        bus_rd(ad(4, 3), 32'h1234_5670, "R8 stored aligned");

        // R5 start
        bus_wr(ad(4, 0), 32'h8000_8000);
        chk("R5 start_pulse high", {31'b0, start_pulse}, 32'h1);
        chk("R5 start_ch", {27'b0, start_ch}, 32'd4);
        chk("R5 no fetch on start", {31'b0, fetch_req}, 32'h0);
        @(posedge clk); #1;
        chk("R5 start one cycle", {31'b0, start_pulse}, 32'h0);
        bus_rd(ad(4, 1), 32'h0000_8400, "R5 run sets active");

        // R7 locked pointer, R8 high word free
        bus_wr(ad(4, 3), 32'hAAAA_0000);
        chk("R7 no fetch while running", {31'b0, fetch_req}, 32'h0);
        bus_rd(ad(4, 3), 32'h1234_5670, "R7 pointer kept");
        bus_wr(ad(4, 2), 32'h0000_0055);
        bus_rd(ad(4, 2), 32'h0000_0055, "R8 pointer high unlocked");

        // R5 no second pulse while running
        bus_wr(ad(4, 0), 32'h8000_8000);
        chk("R5 no pulse when running", {31'b0, start_pulse}, 32'h0);

        // R6 stop
        bus_wr(ad(4, 0), 32'h8000_0000);
        bus_rd(ad(4, 1), 32'h0, "R6 stop clears active");
        bus_wr(ad(4, 3), 32'h0000_0108);
        chk("R6 pointer unlocked after stop", {31'b0, fetch_req}, 32'h1);
        chk("R6 fetch_ptr after stop", fetch_ptr, 32'h0000_0100);

        bus_rd(ad(2, 1), 32'h0000_70A0, "R10 ch2 status unaffected");
        bus_rd(ad(5, 3), 32'h0, "R10 ch5 pointer unaffected");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule